// File: doc/BRIEF.md
# Rotatable Frame-Buffer Scan-Out Controller

This block turns a true-colour frame buffer in word-addressed memory into a pixel stream for a 640x480 TFT or VGA panel. A timing generator outside the block marks the start of each frame and each active pixel and supplies that pixel's column and row. For each such pixel the block works out which memory word holds it, issues one read, and splits the returned word into 8-bit red, green and blue outputs.

Software sees two 32-bit registers: the frame-buffer base address and a control word with a display-enable bit and a half-turn (180-degree) rotate bit. Only the top 11 bits of the base take part in addressing, so a buffer starts on a 2 MiB boundary. Each buffer row spans 1024 words, of which the first 640 are shown. With rotation on, the scan order is reversed in both directions. New register values are picked up only at the next frame start, so one frame never mixes two settings.

Top module: `fbscan_ctrl`

## Requirements
- R1: After reset both registers read zero, the display is disabled, `mem_rd_en` is low and `rgb_valid`, `rgb_red`, `rgb_green`, `rgb_blue` are all zero.
- R2: `reg_sel`=0 selects the base register, which reads back all 32 written bits; `reg_sel`=1 selects the control register, which reads back bits 1:0 as written and zero in bits 31:2. `reg_rdata` shows the selected register combinationally.
- R3: With rotation off, pixel (x, y) is read from word address base[31:21]*2^19 + y*1024 + x (byte address four times that).
- R4: With rotation on (control bit 1 = 1), pixel (x, y) is read from word address base[31:21]*2^19 + (479-y)*1024 + (639-x).
- R5: Base-register bits 20:0 have no effect on the read address.
- R6: While the active configuration has control bit 0 = 0, no read is issued and the RGB outputs stay zero, including for read data that returns after the display was turned off.
- R7: Register writes take effect for addressing only at the next `frame_start`; a write in the same cycle as `frame_start` is used for the frame that begins there.
- R8: One cycle after `mem_rvalid`, with the display enabled, `rgb_valid` is 1 and red, green, blue are bits 23:16, 15:8 and 7:0 of `mem_rdata`; bits 31:24 are ignored. When `rgb_valid` is 0 the colour outputs are zero.
- R9: `mem_rd_en` rises for exactly one cycle, one cycle after each accepted `pix_strobe`, with `mem_addr` valid in that cycle.
- R10: A `pix_strobe` with x >= 640 or y >= 480 issues no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| frame_start | input | 1 | Start-of-frame strobe; loads the active configuration |
| pix_strobe | input | 1 | Active-pixel strobe |
| pix_x | input | 10 | Column of the strobed pixel |
| pix_y | input | 9 | Row of the strobed pixel |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 30 | Memory word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| rgb_valid | output | 1 | Pixel output valid |
| rgb_red | output | 8 | Red level |
| rgb_green | output | 8 | Green level |
| rgb_blue | output | 8 | Blue level |

## Verification
The two functions that meet in one cycle are a register write and the frame-start latch: the bench drives `reg_wr_en` together with `frame_start`, then strobes a pixel and judges from the address of that first read whether the just-written rotation and enable were used. A second collision is a read still in flight when a frame start turns the display off; the bench issues a read, disables in the next cycle, and expects the returned word to produce no valid pixel and zero colour. A behavioural model in the bench tracks registers, active settings, reads and outputs and is compared on every cycle, also through a long phase of mixed random writes, frame starts and pixel strobes.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

    localparam int H_PIX       = 640;
    localparam int V_PIX       = 480;
    localparam int ROW_SHIFT   = 10;
    localparam int DATA_W      = 32;
    localparam int BYTE_ADDR_W = 32;
    localparam int KEEP_BITS   = 11;
    localparam int CHAN_W      = 8;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_ROT_BIT = 1;
    localparam int CTL_W       = 2;

    localparam int WORD_ADDR_W = BYTE_ADDR_W - 2;
    localparam int OFFS_W      = WORD_ADDR_W - KEEP_BITS;
    localparam int X_W         = $clog2(H_PIX);
    localparam int Y_W         = $clog2(V_PIX);

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [KEEP_BITS-1:0] base_hi;
        logic                 rotate;
        logic                 enable;
    } scan_cfg_t;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
    } rgb_t;

    function automatic logic [OFFS_W-1:0] scan_offset(
        input logic [X_W-1:0] x,
        input logic [Y_W-1:0] y,
        input logic           rot
    );
        logic [X_W-1:0] col;
        logic [Y_W-1:0] row;
        col = rot ? (X_W'(H_PIX - 1) - x) : x;
        row = rot ? (Y_W'(V_PIX - 1) - y) : y;
        return (OFFS_W'(row) << ROW_SHIFT) | OFFS_W'(col);
    endfunction

endpackage

// File: rtl/fbscan_regs.sv
module fbscan_regs
    import fbscan_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int KEEP = KEEP_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    input  logic          frame_start,
    output logic [DW-1:0] rdata,
    output scan_cfg_t     act_cfg
);
    logic [DW-1:0]    base_q;
    logic [CTL_W-1:0] ctrl_q;
    logic             wr_base;
    logic             wr_ctrl;
    logic [KEEP-1:0]  next_hi;
    logic [CTL_W-1:0] next_ctrl;
    scan_cfg_t        cfg_q;

    assign wr_base = wr_en && (sel == SEL_BASE);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);

    // value seen by a frame start in the same cycle as a write
    assign next_hi   = wr_base ? wdata[DW-1 -: KEEP] : base_q[DW-1 -: KEEP];
    assign next_ctrl = wr_ctrl ? wdata[CTL_W-1:0]    : ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_base) base_q <= wdata;
            if (wr_ctrl) ctrl_q <= wdata[CTL_W-1:0];
            if (frame_start) begin
                cfg_q.base_hi <= next_hi;
                cfg_q.rotate  <= next_ctrl[CTL_ROT_BIT];
                cfg_q.enable  <= next_ctrl[CTL_EN_BIT];
            end
        end
    end

    assign rdata   = (sel == SEL_CTRL) ? {{(DW-CTL_W){1'b0}}, ctrl_q} : base_q;
    assign act_cfg = cfg_q;

    AST_CFG_HOLD_MID_FRAME: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/fbscan_addr.sv
module fbscan_addr
    import fbscan_pkg::*;
#(
    parameter int XW   = X_W,
    parameter int YW   = Y_W,
    parameter int AW   = WORD_ADDR_W,
    parameter int HPIX = H_PIX,
    parameter int VPIX = V_PIX
) (
    input  logic          clk,
    input  logic          rst,
    input  scan_cfg_t     cfg,
    input  logic          pix_strobe,
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);
    logic          in_frame;
    logic          fire;
    logic          rd_q;
    logic [AW-1:0] addr_q;

    assign in_frame = (int'(pix_x) < HPIX) && (int'(pix_y) < VPIX);
    assign fire     = pix_strobe && cfg.enable && in_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            rd_q <= fire;
            if (fire) addr_q <= {cfg.base_hi, scan_offset(pix_x, pix_y, cfg.rotate)};
        end
    end

    assign rd_en   = rd_q;
    assign rd_addr = addr_q;

    AST_RD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> $past(pix_strobe)); // R9
    AST_RD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> $past(cfg.enable)); // R6
    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> (int'(addr_q[ROW_SHIFT-1:0]) < HPIX)); // R3
    AST_ROW_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> (int'(addr_q[ROW_SHIFT +: YW]) < VPIX)); // R4

endmodule

// File: rtl/fbscan_unpack.sv
module fbscan_unpack
    import fbscan_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          word_valid,
    input  logic [DW-1:0] word,
    output logic          pix_valid,
    output rgb_t          pixel
);
    localparam int NCHAN = 3;

    logic [CW-1:0] chan [NCHAN];
    logic          take;
    logic          valid_q;
    rgb_t          pix_q;
    logic          unused_top;

    // channel c sits at bits c*CW +: CW (0 blue, 1 green, 2 red)
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        assign chan[c] = word[c*CW +: CW];
    end
    assign unused_top = ^word[DW-1:NCHAN*CW];

    assign take = word_valid && enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            pix_q   <= '0;
        end else begin
            valid_q <= take;
            if (take) begin
                pix_q.red   <= chan[2];
                pix_q.green <= chan[1];
                pix_q.blue  <= chan[0];
            end else begin
                pix_q <= '0;
            end
        end
    end

    assign pix_valid = valid_q;
    assign pixel     = pix_q;

    AST_VALID_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(word_valid)); // R8
    AST_DARK_AFTER_OFF: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> (pix_q == '0)); // R6

endmodule

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
    import fbscan_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr_en,
    input  logic                   reg_sel,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   frame_start,
    input  logic                   pix_strobe,
    input  logic [X_W-1:0]         pix_x,
    input  logic [Y_W-1:0]         pix_y,
    output logic                   mem_rd_en,
    output logic [WORD_ADDR_W-1:0] mem_addr,
    input  logic                   mem_rvalid,
    input  logic [DATA_W-1:0]      mem_rdata,
    output logic                   rgb_valid,
    output logic [CHAN_W-1:0]      rgb_red,
    output logic [CHAN_W-1:0]      rgb_green,
    output logic [CHAN_W-1:0]      rgb_blue
);
    scan_cfg_t act_cfg;
    rgb_t      pixel;

    fbscan_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr_en),
        .sel         (reg_sel),
        .wdata       (reg_wdata),
        .frame_start (frame_start),
        .rdata       (reg_rdata),
        .act_cfg     (act_cfg)
    );

    fbscan_addr u_addr (
        .clk        (clk),
        .rst        (rst),
        .cfg        (act_cfg),
        .pix_strobe (pix_strobe),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_addr)
    );

    fbscan_unpack u_unpack (
        .clk        (clk),
        .rst        (rst),
        .enable     (act_cfg.enable),
        .word_valid (mem_rvalid),
        .word       (mem_rdata),
        .pix_valid  (rgb_valid),
        .pixel      (pixel)
    );

    assign rgb_red   = pixel.red;
    assign rgb_green = pixel.green;
    assign rgb_blue  = pixel.blue;

endmodule

// File: tb/fbscan_ctrl_tb_top.sv
`timescale 1ns/1ps
module fbscan_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        frame_start = 1'b0;
    logic        pix_strobe = 1'b0;
    logic [9:0]  pix_x = '0;
    logic [8:0]  pix_y = '0;
    logic        mem_rd_en;
    logic [29:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        rgb_valid;
    logic [7:0]  rgb_red, rgb_green, rgb_blue;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fbscan_ctrl dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_start(frame_start), .pix_strobe(pix_strobe), .pix_x(pix_x), .pix_y(pix_y),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rgb_valid(rgb_valid), .rgb_red(rgb_red), .rgb_green(rgb_green), .rgb_blue(rgb_blue)
    );

    // memory: content is a function of the word address, two-cycle latency
    function automatic logic [31:0] mem_word(input logic [29:0] a);
        return {~a[7:0], a[23:0] ^ 24'h5A3C96};
    endfunction

    logic        rv1;
    logic [29:0] a1;
    always @(posedge clk) begin
        if (rst) begin
            rv1 <= 1'b0; a1 <= '0; mem_rvalid <= 1'b0; mem_rdata <= '0;
        end else begin
            rv1 <= mem_rd_en; a1 <= mem_addr;
            mem_rvalid <= rv1; mem_rdata <= mem_word(a1);
        end
    end

    function automatic logic [29:0] ref_addr(input logic [31:0] b, input logic r, input int x, input int y);
        longint col, row, v;
        col = r ? 639 - x : x;
        row = r ? 479 - y : y;
        v = longint'(b / 32'h0020_0000) * 524288 + row * 1024 + col;
        return 30'(v);
    endfunction

    // behavioural reference model
    logic [31:0] m_base, m_abase;
    logic [1:0]  m_ctrl;
    logic        m_aen, m_arot;
    logic        e_rd, e_v;
    logic [29:0] e_addr;
    logic [7:0]  e_r, e_g, e_b;

    always @(posedge clk) begin : model
        logic [31:0] nb;
        logic [1:0]  nc;
        logic        tk;
        if (rst) begin
            m_base <= '0; m_ctrl <= '0; m_abase <= '0; m_aen <= 0; m_arot <= 0;
            e_rd <= 0; e_addr <= '0; e_v <= 0; e_r <= 0; e_g <= 0; e_b <= 0;
        end else begin
            nb = (reg_wr_en && !reg_sel) ? reg_wdata : m_base;
            nc = (reg_wr_en && reg_sel) ? reg_wdata[1:0] : m_ctrl;
            m_base <= nb; m_ctrl <= nc;
            if (frame_start) begin
                m_abase <= nb; m_aen <= nc[0]; m_arot <= nc[1];
            end
            e_rd <= pix_strobe && m_aen && (pix_x < 640) && (pix_y < 480);
            if (pix_strobe && m_aen && (pix_x < 640) && (pix_y < 480))
                e_addr <= ref_addr(m_abase, m_arot, int'(pix_x), int'(pix_y));
            tk = mem_rvalid && m_aen;
            e_v <= tk;
            e_r <= tk ? mem_rdata[23:16] : 8'h0;
            e_g <= tk ? mem_rdata[15:8]  : 8'h0;
            e_b <= tk ? mem_rdata[7:0]   : 8'h0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        if (!rst) begin
            chk("R9 mem_rd_en vs model", 32'(mem_rd_en), 32'(e_rd));
            if (e_rd) chk("R3/R4 mem_addr vs model", 32'(mem_addr), 32'(e_addr));
            chk("R8/R6 rgb_valid vs model", 32'(rgb_valid), 32'(e_v));
            chk("R8/R6 rgb vs model", {8'h0, rgb_red, rgb_green, rgb_blue}, {8'h0, e_r, e_g, e_b});
            chk("R2 reg_rdata vs model", reg_rdata, reg_sel ? {30'h0, m_ctrl} : m_base);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_model();
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr_en = 0;
    endtask

    task automatic frame();
        frame_start = 1;
        tick();
        frame_start = 0;
    endtask

    task automatic pix(input int x, input int y);
        pix_strobe = 1; pix_x = 10'(x); pix_y = 9'(y);
        tick();
        pix_strobe = 0;
    endtask

    logic [29:0] a_exp;
    logic [31:0] w_exp;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        reg_sel = 0; #0.1;
        chk("R1 base after reset", reg_rdata, 32'h0);
        reg_sel = 1; #0.1;
        chk("R1 ctrl after reset", reg_rdata, 32'h0);
        chk("R1 no read after reset", 32'(mem_rd_en), 0);
        chk("R1 rgb zero after reset", {7'h0, rgb_valid, rgb_red, rgb_green, rgb_blue}, 32'h0);

        wr(0, 32'h0040_1234);
        wr(1, 32'hFFFF_FFFD);
        reg_sel = 0; #0.1;
        chk("R2 base readback", reg_rdata, 32'h0040_1234);
        reg_sel = 1; #0.1;
        chk("R2 ctrl readback narrow", reg_rdata, 32'h1);
        pix(5, 2);
        chk("R7 no read before frame start", 32'(mem_rd_en), 0);

        frame();
        pix(5, 2);
        chk("R9 read follows strobe", 32'(mem_rd_en), 1);
        a_exp = 30'h0010_0805;
        chk("R3 R5 unrotated address", 32'(mem_addr), 32'(a_exp));
        tick(); tick(); tick();
        w_exp = mem_word(a_exp);
        chk("R8 rgb valid", 32'(rgb_valid), 1);
        chk("R8 unpack fields", {8'h0, rgb_red, rgb_green, rgb_blue}, {8'h0, w_exp[23:0]});

        pix(640, 3);
        chk("R10 column out of range", 32'(mem_rd_en), 0);
        pix(3, 480);
        chk("R10 row out of range", 32'(mem_rd_en), 0);

        // write and frame start in the same cycle
        reg_wr_en = 1; reg_sel = 1; reg_wdata = 32'h3; frame_start = 1;
        tick();
        reg_wr_en = 0; frame_start = 0;
        pix(0, 0);
        chk("R7 R4 rotated origin", 32'(mem_addr), 32'h0017_7E7F);
        pix(639, 479);
        chk("R4 rotated far corner", 32'(mem_addr), 32'h0010_0000);

        // disable pending, read in flight across the switch
        wr(1, 32'h0);
        pix(1, 1);
        chk("R7 still reading mid frame", 32'(mem_rd_en), 1);
        frame();
        tick(); tick();
        chk("R6 in-flight return dropped", {7'h0, rgb_valid, rgb_red, rgb_green, rgb_blue}, 32'h0);
        pix(1, 1);
        chk("R6 no read while disabled", 32'(mem_rd_en), 0);

        wr(0, 32'hFFE0_0000);
        wr(1, 32'h1);
        frame();
        pix(639, 479);
        chk("R3 top of memory", 32'(mem_addr), 32'h3FFF_7E7F);

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                frame_start = 1;
                if ($urandom_range(0, 1) == 1) begin
                    reg_wr_en = 1; reg_sel = 1; reg_wdata = $urandom;
                end
            end else if (r < 8) begin
                reg_wr_en = 1; reg_sel = 1'($urandom_range(0, 1)); reg_wdata = $urandom;
                if (reg_sel) reg_wdata[0] = ($urandom_range(0, 3) != 0);
            end else if (r < 75) begin
                pix_strobe = 1;
                pix_x = 10'($urandom_range(0, 700));
                pix_y = 9'($urandom_range(0, 511));
            end
            reg_sel = reg_wr_en ? reg_sel : 1'($urandom_range(0, 1));
            tick();
            frame_start = 0; reg_wr_en = 0; pix_strobe = 0;
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule